// File: doc/BRIEF.md
# Program Address Trace Compressor

This block turns a stream of instruction fetch addresses into a short stream of variable-length trace packets. It works in three steps. First, a boundary filter drops every fetch that follows its predecessor by one instruction (plus 4). Only the first address of each straight-line run (its entry) and the last one (its exit) are kept. Second, a 16-entry associative dictionary swaps an address it has seen before for its entry number. Two hits on neighbouring entries in a row collapse to a bare marker. Third, an address the dictionary does not hold is compared with the previous such address in 4-bit slices. Only the slices up to the highest one that changed are sent.

A trace collector places the block beside the fetch path. Each fetch is presented with `in_valid`. The block emits at most one packet per cycle through `pkt_valid`, `pkt_fmt`, `pkt_payload` and `pkt_len`. A one-cycle `flush` starts a new trace with no history, so a decoder can rebuild the addresses from the first packet that follows it.

Top module: `ptc_trace_compressor`

## Requirements
- R1: After reset, `pkt_valid` stays low until an address has been accepted.
- R2: An address equal to the previously accepted address plus 4 produces no packet. The first address after reset or flush always goes forward as an entry address.
- R3: When an address is not the previous plus 4, the previous address goes forward (exit), followed by the new one (entry), in that order. The exit is skipped when the previous address was itself an entry. Every forwarded address yields exactly one packet, in forwarding order.
- R4: An address that goes forward on an otherwise idle block yields its packet with `pkt_valid` high exactly two clock edges after the edge that sampled it.
- R5: A dictionary miss gives format code 3. Its payload holds the low slices of the address, up to and including the highest 4-bit slice that differs from the previous miss, with all other bits zero. `pkt_len` is 4 times that slice count. The first miss after reset or flush carries all 8 slices (`pkt_len` 32).
- R6: A dictionary hit that is not a chained hit gives format code 2, `pkt_len` 4 and the entry number in payload bits 3:0. Entries are numbered in insertion order from 0 after reset or flush, wrapping modulo 16.
- R7: A hit whose entry number is the previous hit's number plus one, modulo 16, with no miss in between, gives format code 1, `pkt_len` 0 and payload 0.
- R8: With all 16 entries in use, a new miss overwrites the oldest entry. The address that entry held misses again afterwards.
- R9: A flush clears the dictionary, the previous-miss slices, the hit chain and the filter history. An address presented with the flush counts as the first address of a new trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Fetch address valid this cycle |
| in_addr | input | 32 | Fetch address |
| flush | input | 1 | Start a new trace with no history |
| pkt_valid | output | 1 | Packet valid this cycle |
| pkt_fmt | output | 2 | Format code: 1 chained hit, 2 indexed hit, 3 sliced miss |
| pkt_payload | output | 32 | Index or address slices, unused bits zero |
| pkt_len | output | 6 | Payload length in bits (0, 4 .. 32) |

## Verification
Directed runs cover the behaviours that depend on one particular history. One replays a miss, miss, hit, chained-hit sequence with literal expected packets, which separates the three formats and the slice count. Others cover runs of sequential fetches against one-instruction blocks (is the exit sent or suppressed), a seventeenth distinct miss (FIFO eviction against no eviction), a hit on entry 15 followed by entry 0 (chain wrap), and a flush presented with an address that would otherwise look sequential and hit. A long random run jumps among twenty block entry points, more than the dictionary holds. This mixes hits, chains, evictions, idle gaps and flushes, and the full packet order is compared against a bench model.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the program address trace compressor.
// Assumes nothing beyond a 2-bit packet format field.
package ptc_pkg;
    typedef enum logic [1:0] {
        PKT_NONE  = 2'd0,
        PKT_CHAIN = 2'd1,
        PKT_INDEX = 2'd2,
        PKT_SLICE = 2'd3
    } pkt_fmt_e;
endpackage

// File: rtl/ptc_block_filter.sv
`timescale 1ns/1ps
// Basic-block boundary filter. Forwards the entry and exit addresses of each
// straight-line run and drops the fetches in between. A run ending in a
// discontinuity can yield two addresses in one cycle. The second waits in a
// one-deep hold slot. This is enough because such a cycle always follows a
// cycle that yielded nothing. A flush discards the hold slot and the history,
// and it is passed on (o_clr) alongside the first address of the new trace.
module ptc_block_filter #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic          flush,
    output logic          o_valid,
    output logic [AW-1:0] o_addr,
    output logic          o_clr
);
    logic [AW-1:0] prev_q, held_q, e0, e1;
    logic          prev_ok_q, prev_tgt_q, held_vld_q, seq;
    logic [1:0]    n_new;
    logic          nxt_v, nxt_hv;
    logic [AW-1:0] nxt_a, nxt_ha;

    assign seq = prev_ok_q && (in_addr == prev_q + AW'(STEP));

    // Decide how many addresses this input forwards (0, 1 or 2).
    always_comb begin
        n_new = 2'd0;
        e0    = in_addr;
        e1    = in_addr;
        if (flush) begin
            if (in_valid) n_new = 2'd1;
        end else if (in_valid) begin
            if (!prev_ok_q) begin
                n_new = 2'd1;
            end else if (!seq) begin
                if (prev_tgt_q) begin
                    n_new = 2'd1;
                end else begin
                    n_new = 2'd2;
                    e0    = prev_q;
                end
            end
        end
    end

    // Merge the hold slot with the new addresses, oldest first.
    always_comb begin
        if (flush) begin
            nxt_v  = (n_new != 2'd0);
            nxt_a  = e0;
            nxt_hv = 1'b0;
            nxt_ha = e1;
        end else if (held_vld_q) begin
            nxt_v  = 1'b1;
            nxt_a  = held_q;
            nxt_hv = (n_new != 2'd0);
            nxt_ha = e0;
        end else begin
            nxt_v  = (n_new != 2'd0);
            nxt_a  = e0;
            nxt_hv = (n_new == 2'd2);
            nxt_ha = e1;
        end
    end

    // Register the forwarded address, the hold slot and the fetch history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= '0;
            prev_ok_q  <= 1'b0;
            prev_tgt_q <= 1'b0;
            held_q     <= '0;
            held_vld_q <= 1'b0;
            o_valid    <= 1'b0;
            o_addr     <= '0;
            o_clr      <= 1'b0;
        end else begin
            o_valid    <= nxt_v;
            o_addr     <= nxt_a;
            o_clr      <= flush;
            held_vld_q <= nxt_hv;
            held_q     <= nxt_ha;
            if (in_valid) begin
                prev_q     <= in_addr;
                prev_ok_q  <= 1'b1;
                prev_tgt_q <= flush || !seq;
            end else if (flush) begin
                prev_ok_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ptc_addr_dict.sv
`timescale 1ns/1ps
// Associative address dictionary with oldest-first replacement. The lookup is
// combinational. A write stores the lookup address at the insertion pointer.
// A clear takes effect for this cycle's lookup and write, so a write in a
// clear cycle lands in entry 0. DEPTH must be a power of two, which lets the
// pointer wrap on its own.
module ptc_addr_dict #(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW-1:0] look_addr,
    input  logic          wr_en,
    output logic          hit,
    output logic [IW-1:0] hit_idx
);
    logic [AW-1:0]    ent_q [DEPTH];
    logic [DEPTH-1:0] vld_q, vld_eff, match;
    logic [IW-1:0]    ptr_q, wptr;

    assign vld_eff = clr ? '0 : vld_q;
    assign wptr    = clr ? '0 : ptr_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = vld_eff[i] && (ent_q[i] == look_addr);
    end

    assign hit = |match;

    // Encode the matching entry; stored addresses are unique.
    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IW'(i);
        end
    end

    // Track valid entries and the insertion pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else begin
            vld_q <= vld_eff | (wr_en ? (DEPTH'(1) << wptr) : '0);
            if (wr_en)    ptr_q <= wptr + IW'(1);
            else if (clr) ptr_q <= '0;
        end
    end

    // Store address data; valid bits gate it, so it needs no reset.
    always_ff @(posedge clk) begin
        if (wr_en) ent_q[wptr] <= look_addr;
    end
endmodule

// File: rtl/ptc_slice_enc.sv
`timescale 1ns/1ps
// Slice comparator. Splits the address into SW-bit slices and finds the
// highest slice that differs from the reference. It outputs the low slices up
// to that one, with higher bits zeroed, and the bit length. Without a valid
// reference all slices are kept. If the addresses are equal, one slice is kept.
module ptc_slice_enc #(
    parameter int AW  = 32,
    parameter int SW  = 4,
    localparam int NSL = AW / SW,
    localparam int CW  = $clog2(NSL + 1),
    localparam int LW  = $clog2(AW + 1)
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] ref_addr,
    input  logic          ref_ok,
    output logic [AW-1:0] payload,
    output logic [LW-1:0] len
);
    logic [NSL-1:0] dif;
    logic [CW-1:0]  top, nsl;

    for (genvar s = 0; s < NSL; s++) begin : g_slice
        assign dif[s] = cur[s*SW +: SW] != ref_addr[s*SW +: SW];
        assign payload[s*SW +: SW] = (CW'(s) < nsl) ? cur[s*SW +: SW] : '0;
    end

    // Find the count of slices up to the highest differing one.
    always_comb begin
        top = CW'(1);
        for (int s = 0; s < NSL; s++) begin
            if (dif[s]) top = CW'(s + 1);
        end
        nsl = ref_ok ? top : CW'(NSL);
    end

    assign len = LW'(32'(nsl) * SW);
endmodule

// File: rtl/ptc_trace_compressor.sv
`timescale 1ns/1ps
// Program address trace compressor, top level. Stage 1 filters block
// boundaries. Stage 2 looks the address up in the dictionary, checks the hit
// chain, or slice-encodes a miss, and registers one packet. The latency is two
// edges. A miss clears the hit chain. A flush is pipelined with its address so
// that the stage-2 history clears before that address is looked up.
module ptc_trace_compressor #(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    parameter int SW    = 4,
    parameter int STEP  = 4,
    localparam int IW   = $clog2(DEPTH),
    localparam int LW   = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic          flush,
    output logic          pkt_valid,
    output logic [1:0]    pkt_fmt,
    output logic [AW-1:0] pkt_payload,
    output logic [LW-1:0] pkt_len
);
    import ptc_pkg::*;

    logic          s1_valid, s1_clr;
    logic [AW-1:0] s1_addr;
    logic          hit, chain;
    logic [IW-1:0] hit_idx, nxt_idx;
    logic [AW-1:0] lm_q, sl_payload;
    logic          lm_ok_q, hh_ok_q, lm_ok_eff, hh_ok_eff;
    logic [IW-1:0] hh_idx_q;
    logic [LW-1:0] sl_len;

    ptc_block_filter #(.AW(AW), .STEP(STEP)) i_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .flush(flush), .o_valid(s1_valid), .o_addr(s1_addr), .o_clr(s1_clr)
    );

    ptc_addr_dict #(.AW(AW), .DEPTH(DEPTH)) i_dict (
        .clk(clk), .rst_n(rst_n), .clr(s1_clr), .look_addr(s1_addr),
        .wr_en(s1_valid && !hit), .hit(hit), .hit_idx(hit_idx)
    );

    assign lm_ok_eff = lm_ok_q && !s1_clr;
    assign hh_ok_eff = hh_ok_q && !s1_clr;

    ptc_slice_enc #(.AW(AW), .SW(SW)) i_slice (
        .cur(s1_addr), .ref_addr(lm_q), .ref_ok(lm_ok_eff),
        .payload(sl_payload), .len(sl_len)
    );

    assign nxt_idx = hh_idx_q + IW'(1);
    assign chain   = hit && hh_ok_eff && (hit_idx == nxt_idx);

    // Keep the previous miss and the hit-chain history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lm_q     <= '0;
            lm_ok_q  <= 1'b0;
            hh_idx_q <= '0;
            hh_ok_q  <= 1'b0;
        end else begin
            if (s1_clr) begin
                lm_ok_q <= 1'b0;
                hh_ok_q <= 1'b0;
            end
            if (s1_valid) begin
                if (hit) begin
                    hh_idx_q <= hit_idx;
                    hh_ok_q  <= 1'b1;
                end else begin
                    lm_q    <= s1_addr;
                    lm_ok_q <= 1'b1;
                    hh_ok_q <= 1'b0;
                end
            end
        end
    end

    // Build and register the output packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_valid   <= 1'b0;
            pkt_fmt     <= PKT_NONE;
            pkt_payload <= '0;
            pkt_len     <= '0;
        end else begin
            pkt_valid <= s1_valid;
            if (!s1_valid) begin
                pkt_fmt     <= PKT_NONE;
                pkt_payload <= '0;
                pkt_len     <= '0;
            end else if (chain) begin
                pkt_fmt     <= PKT_CHAIN;
                pkt_payload <= '0;
                pkt_len     <= '0;
            end else if (hit) begin
                pkt_fmt     <= PKT_INDEX;
                pkt_payload <= AW'(hit_idx);
                pkt_len     <= LW'(IW);
            end else begin
                pkt_fmt     <= PKT_SLICE;
                pkt_payload <= sl_payload;
                pkt_len     <= sl_len;
            end
        end
    end
endmodule

// File: rtl/ptc_checker.sv
`timescale 1ns/1ps
// Port-level protocol checks for the trace compressor, bound to the top.
module ptc_checker #(
    parameter int AW = 32,
    parameter int LW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          flush,
    input logic          pkt_valid,
    input logic [1:0]    pkt_fmt,
    input logic [AW-1:0] pkt_payload,
    input logic [LW-1:0] pkt_len
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !pkt_valid); // R1
    AST_FMT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_fmt != 2'd0); // R3
    AST_SLICE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_fmt == 2'd3) |->
        (pkt_len != '0 && pkt_len[1:0] == 2'b00 && pkt_len <= LW'(AW)
         && (pkt_payload >> pkt_len) == '0)); // R5
    AST_INDEX_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_fmt == 2'd2) |-> (pkt_len == LW'(4) && pkt_payload[AW-1:4] == '0)); // R6
    AST_CHAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_fmt == 2'd1) |-> (pkt_len == '0 && pkt_payload == '0)); // R7
    AST_FLUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush, 2) && $past(in_valid, 2)) |->
        (pkt_valid && pkt_fmt == 2'd3 && pkt_len == LW'(AW))); // R9
endmodule

bind ptc_trace_compressor ptc_checker #(.AW(AW), .LW(LW)) i_ptc_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flush(flush),
    .pkt_valid(pkt_valid), .pkt_fmt(pkt_fmt), .pkt_payload(pkt_payload),
    .pkt_len(pkt_len)
);

// File: tb/test_ptc_trace_compressor.sv
`timescale 1ns/1ps
module test_ptc_trace_compressor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        flush = 1'b0;
    logic        pkt_valid;
    logic [1:0]  pkt_fmt;
    logic [31:0] pkt_payload;
    logic [5:0]  pkt_len;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    ptc_trace_compressor i_ptc_trace_compressor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .flush(flush), .pkt_valid(pkt_valid), .pkt_fmt(pkt_fmt),
        .pkt_payload(pkt_payload), .pkt_len(pkt_len)
    );

    // expected packet queue: {fmt, len, payload}
    logic [39:0] q_exp[$];
    string       q_tag[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic exp_push(input logic [1:0] f, input int len, input logic [31:0] pay, input string tag);
        q_exp.push_back({f, len[5:0], pay});
        q_tag.push_back(tag);
    endtask

    // packet monitor: compare each packet with the next expected one
    always @(negedge clk) begin
        if (rst_n && pkt_valid) begin
            if (q_exp.size() == 0) begin
                chk(1'b0, "R2 unexpected packet", {24'd0, pkt_fmt, pkt_len, pkt_payload}, 64'd0);
            end else begin
                logic [39:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                chk({pkt_fmt, pkt_len, pkt_payload} == e, t,
                    {24'd0, pkt_fmt, pkt_len, pkt_payload}, {24'd0, e});
            end
        end
    end

    // ---------------- bench model from the requirements ----------------
    logic [31:0] md_addr[16];
    bit          md_vld[16];
    int          md_ptr, md_hh;
    bit          md_hh_ok, md_lm_ok;
    logic [31:0] md_lm, mf_prev;
    bit          mf_ok, mf_tgt;

    task automatic m_reset();
        for (int i = 0; i < 16; i++) md_vld[i] = 1'b0;
        md_ptr = 0; md_hh = 0; md_hh_ok = 1'b0; md_lm_ok = 1'b0; md_lm = '0;
        mf_ok = 1'b0; mf_tgt = 1'b0; mf_prev = '0;
    endtask

    task automatic m_dict(input logic [31:0] a, input string tag);
        int idx;
        idx = -1;
        for (int i = 0; i < 16; i++) if (md_vld[i] && md_addr[i] == a) idx = i;
        if (idx >= 0) begin
            if (md_hh_ok && idx == (md_hh + 1) % 16) exp_push(2'd1, 0, 32'd0, {tag, " R7"});
            else exp_push(2'd2, 4, idx[31:0], {tag, " R6"});
            md_hh = idx; md_hh_ok = 1'b1;
        end else begin
            int nsl;
            logic [31:0] m;
            nsl = 8;
            if (md_lm_ok) begin
                nsl = 1;
                for (int s = 0; s < 8; s++) if (a[s*4 +: 4] != md_lm[s*4 +: 4]) nsl = s + 1;
            end
            m = (nsl == 8) ? 32'hffff_ffff : ((32'd1 << (4 * nsl)) - 32'd1);
            exp_push(2'd3, 4 * nsl, a & m, {tag, " R5"});
            md_addr[md_ptr] = a; md_vld[md_ptr] = 1'b1; md_ptr = (md_ptr + 1) % 16;
            md_lm = a; md_lm_ok = 1'b1; md_hh_ok = 1'b0;
        end
    endtask

    task automatic m_feed(input logic [31:0] a, input string tag);
        bit sq;
        sq = mf_ok && (a == mf_prev + 32'd4);
        if (!mf_ok) m_dict(a, tag);
        else if (!sq) begin
            if (!mf_tgt) m_dict(mf_prev, {tag, " R3"});
            m_dict(a, tag);
        end
        mf_tgt = !sq; mf_prev = a; mf_ok = 1'b1;
    endtask

    // ---------------- stimulus helpers ----------------
    task automatic drive(input bit v, input logic [31:0] a, input bit f);
        @(negedge clk);
        in_valid = v; in_addr = a; flush = f;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 32'd0, 1'b0);
    endtask

    task automatic send(input logic [31:0] a, input string tag);
        drive(1'b1, a, 1'b0);
        m_feed(a, tag);
    endtask

    task automatic clean_flush();
        idle(3);
        drive(1'b0, 32'd0, 1'b1);
        m_reset();
        idle(3);
    endtask

    task automatic flush_with(input logic [31:0] a, input string tag);
        idle(3);
        drive(1'b1, a, 1'b1);
        m_reset();
        m_feed(a, tag);
    endtask

    task automatic drain(input string tag);
        idle(6);
        chk(q_exp.size() == 0, tag, q_exp.size(), 64'd0);
    endtask

    // watchdog
    initial begin
        #(4 * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    logic [31:0] bases[20];

    initial begin
        logic [31:0] cur;
        m_reset();
        void'($urandom(32'h1c0ffee5));
        idle(5);
        rst_n = 1'b1;
        // R1: quiet after reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(pkt_valid == 1'b0, "R1 idle after reset", pkt_valid, 0);
        end

        // R5 R6 R7: miss, short miss, indexed hit, chained hit (literal values)
        clean_flush();
        drive(1'b1, 32'h0000_8020, 1'b0); exp_push(2'd3, 32, 32'h0000_8020, "R5 full miss");
        drive(1'b1, 32'h0000_8030, 1'b0); exp_push(2'd3, 8,  32'h0000_0030, "R5 two slices");
        drive(1'b1, 32'h0000_8020, 1'b0); exp_push(2'd2, 4,  32'h0, "R6 index 0");
        drive(1'b1, 32'h0000_8030, 1'b0); exp_push(2'd1, 0,  32'h0, "R7 chained");
        drain("R3 packet count");

        // R2 R3: sequential run dropped, exit then entry forwarded
        clean_flush();
        drive(1'b1, 32'h0000_1000, 1'b0); exp_push(2'd3, 32, 32'h0000_1000, "R2 first entry");
        drive(1'b1, 32'h0000_1004, 1'b0);
        drive(1'b1, 32'h0000_1008, 1'b0);
        drive(1'b1, 32'h0000_2000, 1'b0);
        exp_push(2'd3, 4,  32'h0000_0008, "R3 exit address");
        exp_push(2'd3, 16, 32'h0000_2000, "R3 entry address");
        drain("R2 no packet for sequential");

        // R4: latency of two edges
        clean_flush();
        drive(1'b1, 32'h00ab_cd00, 1'b0); exp_push(2'd3, 32, 32'h00ab_cd00, "R4 packet");
        drive(1'b0, 32'd0, 1'b0);
        chk(pkt_valid == 1'b0, "R4 not after one edge", pkt_valid, 0);
        drive(1'b0, 32'd0, 1'b0);
        chk(pkt_valid == 1'b1, "R4 valid after two edges", pkt_valid, 1);
        drain("R4 packet count");

        // R8: seventeenth miss evicts entry 0
        clean_flush();
        for (int k = 1; k <= 17; k++) send(32'h100 * k, "R8 fill");
        send(32'h0000_0100, "R8 evicted readdress");
        send(32'h0000_0300, "R8 survivor");
        send(32'h0000_0400, "R8 survivor next");
        drain("R8 packet count");

        // R7: chain wraps from entry 15 to entry 0
        clean_flush();
        for (int k = 1; k <= 16; k++) send(32'h100 * k, "R7 fill");
        send(32'h0000_1000, "R7 entry 15");
        send(32'h0000_0100, "R7 wrap to 0");
        drain("R7 packet count");

        // R9: flush clears dictionary and filter history (literal values)
        clean_flush();
        drive(1'b1, 32'h0000_5000, 1'b0); exp_push(2'd3, 32, 32'h0000_5000, "R9 before flush");
        drive(1'b1, 32'h0000_6000, 1'b0); exp_push(2'd3, 16, 32'h0000_6000, "R9 before flush");
        idle(3);
        drive(1'b1, 32'h0000_6004, 1'b1); exp_push(2'd3, 32, 32'h0000_6004, "R9 first after flush");
        drive(1'b1, 32'h0000_5000, 1'b0); exp_push(2'd3, 16, 32'h0000_5000, "R9 dictionary cleared");
        drive(1'b1, 32'h0000_6004, 1'b0); exp_push(2'd2, 4,  32'h0, "R9 new entry 0");
        drive(1'b1, 32'h0000_5000, 1'b0); exp_push(2'd1, 0,  32'h0, "R9 new chain");
        drain("R9 packet count");

        // random phase over twenty block entry points
        for (int i = 0; i < 20; i++) bases[i] = (32'h0004_0000 + i * 32'h0000_1230 + i * i * 32'h40) & ~32'h3;
        clean_flush();
        cur = bases[0];
        send(cur, "rand");
        for (int it = 0; it < 2500; it++) begin
            int r;
            r = $urandom % 100;
            if (r < 55) begin
                cur = cur + 32'd4; send(cur, "rand seq R2");
            end else if (r < 90) begin
                cur = bases[$urandom % 20]; send(cur, "rand jump");
            end else if (r < 96) begin
                idle(1);
            end else if (r < 98) begin
                cur = $urandom & ~32'h3; send(cur, "rand far");
            end else if (r < 99) begin
                clean_flush();
            end else begin
                cur = bases[$urandom % 20]; flush_with(cur, "rand flush R9");
            end
        end
        drain("R3 random packet count");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule